// File: doc/BRIEF.md
# Shared Receive/Transmit Packet Buffer

This block is a single byte store that a packet receiver, a packet transmitter and a controller all share. The controller reaches any byte in one clock, either counting up from the first byte or down from the last byte. Read data appears on the cycle after the request, and a write lands at the clock edge that samples it.

The receive and transmit paths lay out a frame differently. A received frame's length byte goes into a separate readable register. Its payload is written from byte 0 upward, and a link-quality byte follows the last payload byte. The transmit reader expects the frame length in byte 0 and the payload in the bytes after it. It streams that payload out over a valid/ready handshake. Because of this, a received frame cannot be sent back without first being rewritten.

An optional protection mode locks the store once a complete frame has arrived. Later frames are then discarded and counted until software releases the lock.

Top module: `frame_buffer_shared`

## Requirements
- R1: A controller read (`cpu_en`=1, `cpu_we`=0) presents the addressed byte on `cpu_rdata` one cycle later, with no wait states. `cpu_rdata` holds its value when no read is requested. A controller write updates the byte at the sampling edge. After reset every byte, `cpu_rdata`, `frame_len`, `locked` and `drop_cnt` are zero.
- R2: With `cpu_from_end`=0, `cpu_idx` selects byte `cpu_idx`. With `cpu_from_end`=1, it selects byte DEPTH-1-`cpu_idx`.
- R3: A `rx_start` pulse that is accepted loads `rx_len` into `frame_len`. `frame_len` changes at no other time. The length byte itself is never written into the store.
- R4: Each `rx_valid` byte of an accepted frame is written at the next index, starting from 0. On `rx_done`, `rx_lqi` is written at the index just after the last payload byte. Bytes whose index would be DEPTH or more are discarded. Within one cycle, `rx_start` has priority over `rx_valid`, and `rx_valid` has priority over `rx_done`.
- R5: Stored bytes change only through receive writes or controller writes. Streaming a frame out leaves the store unchanged.
- R6: An accepted `tx_start` reads byte 0 as the length L, clamped to DEPTH-1. It then presents bytes 1..L in order on `tx_data`, with `tx_valid` high and `tx_busy` high. A byte advances only when `tx_ready` is high, and `tx_last` marks byte L.
- R7: A `tx_start` that finds L=0 produces no output, and `tx_busy` stays low.
- R8: `tx_start` is ignored while a received frame is in progress (between the accepted `rx_start` and `rx_done`) and while `tx_busy` is high.
- R9: When `prot_en` is high at `rx_done`, `locked` rises. While `locked` is high, each `rx_start` is rejected: that frame's bytes and done pulse have no effect, and `drop_cnt` increments, saturating at its maximum.
- R10: `lock_clr` clears `locked` and takes priority over a lock being set in the same cycle. With `prot_en` low, `locked` never rises.
- R11: If a receive write and a controller write fall in the same cycle, the receive write is performed and the controller write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | Controller access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_from_end | input | 1 | Index counts down from the last byte |
| cpu_idx | input | AW | Byte index |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, one cycle after the request |
| rx_start | input | 1 | Frame start, carries the length |
| rx_len | input | DW | Received frame length |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | DW | Payload byte |
| rx_done | input | 1 | Frame end, carries link quality |
| rx_lqi | input | DW | Link-quality byte |
| prot_en | input | 1 | Enable lock after a complete frame |
| lock_clr | input | 1 | Release the lock |
| frame_len | output | DW | Length of the last accepted frame |
| locked | output | 1 | Store is protected |
| drop_cnt | output | CW | Rejected frames, saturating |
| tx_start | input | 1 | Start streaming the stored frame |
| tx_ready | input | 1 | Transmitter accepts a byte |
| tx_valid | output | 1 | Byte presented |
| tx_data | output | DW | Presented byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_busy | output | 1 | Streaming in progress |

## Verification
The bench keeps the default 128-byte store. This lets a length byte of 200 exercise the clamp to 127 and the end-relative addressing at full span. It narrows the drop counter to 2 bits, so four rejected frames drive it into saturation at 3. A behavioural model tracks a cycle-by-cycle view of the store, the lock and the transmit queue. The bench also covers collisions between the receiver and the controller, and a transmit request issued during a reception.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // map a controller index to a physical byte position
  function automatic int unsigned fb_phys_index(input logic from_end,
                                                input int unsigned idx,
                                                input int unsigned depth);
    return from_end ? (depth - 1 - idx) : idx;
  endfunction

  // transmit length taken from byte 0, limited to what fits after it
  function automatic int unsigned fb_tx_len(input int unsigned raw,
                                            input int unsigned depth);
    return (raw > depth - 1) ? (depth - 1) : raw;
  endfunction
endpackage

// File: rtl/fb_store.sv
module fb_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_we,
  input  logic [AW-1:0] rx_waddr,
  input  logic [DW-1:0] rx_wdata,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_wr_grant,
  input  logic [AW-1:0] tx_raddr,
  output logic [DW-1:0] tx_rdata,
  output logic [DW-1:0] head_byte
);
  logic [DW-1:0] mem [DEPTH];

  // receiver has priority on the single write port
  assign cpu_wr_grant = cpu_en && cpu_we && !rx_we;
  assign tx_rdata     = mem[tx_raddr];
  assign head_byte    = mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cpu_rdata <= '0;
    end else begin
      if (cpu_en && !cpu_we) cpu_rdata <= mem[cpu_addr];
      if (rx_we)             mem[rx_waddr] <= rx_wdata;
      else if (cpu_wr_grant) mem[cpu_addr] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/fb_rx_ctrl.sv
module fb_rx_ctrl #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic [DW-1:0] rx_len,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_lqi,
  input  logic          prot_en,
  input  logic          lock_clr,
  output logic          rx_we,
  output logic [AW-1:0] rx_waddr,
  output logic [DW-1:0] rx_wdata,
  output logic          rx_active,
  output logic [DW-1:0] frame_len,
  output logic          locked,
  output logic [CW-1:0] drop_cnt,
  output logic          frame_accept,
  output logic          frame_drop
);
  logic [PW-1:0] wptr;
  logic          byte_in, tail_in, room;

  assign frame_accept = rx_start && !locked;
  assign frame_drop   = rx_start && locked;
  assign byte_in      = !rx_start && rx_valid && rx_active;
  assign tail_in      = !rx_start && !rx_valid && rx_done && rx_active;
  assign room         = wptr < PW'(DEPTH);
  assign rx_we        = (byte_in || tail_in) && room;
  assign rx_waddr     = wptr[AW-1:0];
  assign rx_wdata     = tail_in ? rx_lqi : rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rx_active <= 1'b0;
      frame_len <= '0;
      locked    <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      if (frame_accept) begin
        rx_active <= 1'b1;
        frame_len <= rx_len;
        wptr      <= '0;
      end else if (byte_in && room) begin
        wptr <= wptr + PW'(1);
      end else if (tail_in) begin
        rx_active <= 1'b0;
      end
      if (frame_drop && drop_cnt != '1) drop_cnt <= drop_cnt + CW'(1);
      if (lock_clr)                 locked <= 1'b0;
      else if (tail_in && prot_en)  locked <= 1'b1;
    end
  end
endmodule

// File: rtl/fb_tx_reader.sv
module fb_tx_reader #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic          rx_active,
  input  logic [DW-1:0] head_byte,
  input  logic [DW-1:0] rd_data,
  input  logic          tx_ready,
  output logic [AW-1:0] rd_addr,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_busy,
  output logic          tx_accept
);
  import fb_pkg::*;
  logic [AW-1:0] ptr, len, start_len;

  assign tx_accept = tx_start && !tx_busy && !rx_active;
  assign start_len = AW'(fb_tx_len(32'(head_byte), DEPTH));
  assign rd_addr   = ptr;
  assign tx_valid  = tx_busy;
  assign tx_data   = rd_data;
  assign tx_last   = tx_busy && (ptr == len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      ptr     <= '0;
      len     <= '0;
    end else if (tx_accept) begin
      len     <= start_len;
      ptr     <= AW'(1);
      tx_busy <= (start_len != '0);
    end else if (tx_busy && tx_ready) begin
      if (ptr == len) tx_busy <= 1'b0;
      else            ptr <= ptr + AW'(1);
    end
  end
endmodule

// File: rtl/frame_buffer_shared.sv
module frame_buffer_shared #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic          cpu_from_end,
  input  logic [AW-1:0] cpu_idx,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rx_start,
  input  logic [DW-1:0] rx_len,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_lqi,
  input  logic          prot_en,
  input  logic          lock_clr,
  output logic [DW-1:0] frame_len,
  output logic          locked,
  output logic [CW-1:0] drop_cnt,
  input  logic          tx_start,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_busy
);
  import fb_pkg::*;

  logic          rx_we, rx_active, frame_accept, frame_drop;
  logic [AW-1:0] rx_waddr, cpu_addr, tx_raddr;
  logic [DW-1:0] rx_wdata, tx_rdata, head_byte;
  logic          cpu_wr_grant, tx_accept;

  assign cpu_addr = AW'(fb_phys_index(cpu_from_end, 32'(cpu_idx), DEPTH));

  fb_rx_ctrl #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_len(rx_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done), .rx_lqi(rx_lqi),
    .prot_en(prot_en), .lock_clr(lock_clr), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .rx_active(rx_active), .frame_len(frame_len),
    .locked(locked), .drop_cnt(drop_cnt), .frame_accept(frame_accept),
    .frame_drop(frame_drop)
  );

  fb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wr_grant(cpu_wr_grant),
    .tx_raddr(tx_raddr), .tx_rdata(tx_rdata), .head_byte(head_byte)
  );

  fb_tx_reader #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_active(rx_active),
    .head_byte(head_byte), .rd_data(tx_rdata), .tx_ready(tx_ready),
    .rd_addr(tx_raddr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_busy(tx_busy), .tx_accept(tx_accept)
  );
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_en,
  input logic          cpu_we,
  input logic          cpu_wr_grant,
  input logic          rx_we,
  input logic          rx_active,
  input logic          frame_accept,
  input logic          frame_drop,
  input logic          prot_en,
  input logic          lock_clr,
  input logic          locked,
  input logic [CW-1:0] drop_cnt,
  input logic [DW-1:0] frame_len,
  input logic          tx_start,
  input logic          tx_ready,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_last,
  input logic          tx_busy
);
  p_len_only_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_accept |=> $stable(frame_len));

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rx_we && !cpu_wr_grant)
      |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_last_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  p_tx_ignored_in_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && rx_active && !tx_busy) |=> !tx_busy);

  p_drop_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_drop && drop_cnt != '1) |=> drop_cnt == $past(drop_cnt) + CW'(1));

  p_no_write_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !rx_we);

  p_lock_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !lock_clr) |=> locked);

  p_no_lock_unprot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && !locked) |=> !locked);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_clr |=> !locked);

  p_rx_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_we && cpu_en && cpu_we) |-> !cpu_wr_grant);
endmodule

bind frame_buffer_shared fb_checker #(.DW(DW), .CW(CW)) u_fb_checker (
  .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we),
  .cpu_wr_grant(cpu_wr_grant), .rx_we(rx_we), .rx_active(rx_active),
  .frame_accept(frame_accept), .frame_drop(frame_drop), .prot_en(prot_en),
  .lock_clr(lock_clr), .locked(locked), .drop_cnt(drop_cnt),
  .frame_len(frame_len), .tx_start(tx_start), .tx_ready(tx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_busy(tx_busy)
);

// File: tb/test_frame_buffer_shared.sv
`timescale 1ns/1ps
module test_frame_buffer_shared;
  localparam int DEPTH = 128;
  localparam int DW    = 8;
  localparam int CW    = 2;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_en = 0, cpu_we = 0, cpu_from_end = 0;
  logic [AW-1:0] cpu_idx = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic rx_start = 0, rx_valid = 0, rx_done = 0, prot_en = 0, lock_clr = 0;
  logic [DW-1:0] rx_len = '0, rx_data = '0, rx_lqi = '0, frame_len, tx_data;
  logic locked, tx_valid, tx_last, tx_busy;
  logic [CW-1:0] drop_cnt;
  logic tx_start = 0, tx_ready = 0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_buffer_shared #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_frame_buffer_shared (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we),
    .cpu_from_end(cpu_from_end), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rx_start(rx_start), .rx_len(rx_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done), .rx_lqi(rx_lqi),
    .prot_en(prot_en), .lock_clr(lock_clr), .frame_len(frame_len),
    .locked(locked), .drop_cnt(drop_cnt), .tx_start(tx_start),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_busy(tx_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_mem [DEPTH];
  int  m_rdata, m_len, m_drop, m_ptr;
  bit  m_locked, m_active;
  int  m_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_rdata = 0; m_len = 0; m_drop = 0; m_ptr = 0;
      m_locked = 0; m_active = 0; m_q.delete();
    end else begin
      int  snap [DEPTH];
      int  pos, l;
      bit  was_active, was_locked, rx_wrote;
      snap = m_mem;
      was_active = m_active;
      was_locked = m_locked;
      rx_wrote = 0;
      pos = cpu_from_end ? (DEPTH - 1 - int'(cpu_idx)) : int'(cpu_idx);
      if (cpu_en && !cpu_we) m_rdata = snap[pos];
      if (rx_start) begin
        if (was_locked) begin
          if (m_drop < (1 << CW) - 1) m_drop++;
        end else begin
          m_active = 1; m_len = rx_len; m_ptr = 0;
        end
      end else if (rx_valid && was_active) begin
        if (m_ptr < DEPTH) begin
          m_mem[m_ptr] = rx_data; rx_wrote = 1; m_ptr++;
        end
      end else if (rx_done && was_active) begin
        if (m_ptr < DEPTH) begin
          m_mem[m_ptr] = rx_lqi; rx_wrote = 1;
        end
        m_active = 0;
        if (prot_en) m_locked = 1;
      end
      if (lock_clr) m_locked = 0;
      if (cpu_en && cpu_we && !rx_wrote) m_mem[pos] = cpu_wdata;
      if (tx_start && m_q.size() == 0 && !was_active) begin
        l = (snap[0] > DEPTH - 1) ? DEPTH - 1 : snap[0];
        for (int k = 1; k <= l; k++) m_q.push_back(snap[k]);
      end else if (m_q.size() != 0 && tx_ready) begin
        void'(m_q.pop_front());
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always begin
    @(posedge clk); #1;
    if (rst_n && !finished) begin
      chk("R1 cpu_rdata", cpu_rdata, m_rdata);
      chk("R3 frame_len", frame_len, m_len);
      chk("R9 locked", locked, m_locked);
      chk("R9 drop_cnt", drop_cnt, m_drop);
      chk("R6 tx_valid", tx_valid, m_q.size() != 0);
      chk("R8 tx_busy", tx_busy, m_q.size() != 0);
      chk("R6 tx_last", tx_last, m_q.size() == 1);
      if (m_q.size() != 0) chk("R6 tx_data", tx_data, m_q[0]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle_inputs();
    cpu_en = 0; cpu_we = 0; rx_start = 0; rx_valid = 0; rx_done = 0;
    tx_start = 0; lock_clr = 0;
  endtask

  task automatic cpu_wr(input bit fe, input int idx, input int d);
    @(negedge clk); idle_inputs();
    cpu_en = 1; cpu_we = 1; cpu_from_end = fe; cpu_idx = AW'(idx); cpu_wdata = DW'(d);
    @(negedge clk); idle_inputs();
  endtask

  task automatic cpu_rd(input bit fe, input int idx, output int val);
    @(negedge clk); idle_inputs();
    cpu_en = 1; cpu_we = 0; cpu_from_end = fe; cpu_idx = AW'(idx);
    @(negedge clk); idle_inputs();
    val = cpu_rdata;
  endtask

  task automatic rx_frame(input int len, input int base, input int lqi);
    @(negedge clk); idle_inputs();
    rx_start = 1; rx_len = DW'(len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); idle_inputs();
      if (i % 2 == 1) begin @(negedge clk); end
      rx_valid = 1; rx_data = DW'(base + i);
    end
    @(negedge clk); idle_inputs();
    rx_done = 1; rx_lqi = DW'(lqi);
    @(negedge clk); idle_inputs();
  endtask

  task automatic tx_run(output int shakes);
    shakes = 0;
    @(negedge clk); idle_inputs();
    tx_start = 1; tx_ready = 0;
    @(negedge clk); idle_inputs();
    for (int k = 0; k < 600 && tx_busy; k++) begin
      tx_ready = (k % 3 != 1);
      if (tx_valid && tx_ready) shakes++;
      @(negedge clk);
    end
    tx_ready = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rdata", cpu_rdata, 0);
    chk("R1 reset locked", locked, 0);
    chk("R1 reset tx_busy", tx_busy, 0);

    // R1 R2: write from base, read from end
    cpu_wr(0, 5, 8'hA5);
    cpu_rd(1, DEPTH - 1 - 5, v);  chk("R2 end-relative read", v, 8'hA5);
    cpu_wr(1, 0, 8'h3C);
    cpu_rd(0, DEPTH - 1, v);      chk("R2 last byte", v, 8'h3C);

    // R3 R4: received frame layout
    rx_frame(5, 8'h11, 8'h7E);
    chk("R3 length held", frame_len, 5);
    cpu_rd(0, 0, v);  chk("R4 first payload", v, 8'h11);
    cpu_rd(0, 4, v);  chk("R4 last payload", v, 8'h15);
    cpu_rd(0, 5, v);  chk("R4 link quality after payload", v, 8'h7E);

    // R6 R5: transmit layout with stalls
    cpu_wr(0, 0, 4);
    for (int i = 1; i <= 4; i++) cpu_wr(0, i, 8'hC0 + i);
    tx_run(n);
    chk("R6 bytes streamed", n, 4);
    cpu_rd(0, 0, v);  chk("R5 length byte kept", v, 4);
    cpu_rd(0, 3, v);  chk("R5 payload kept", v, 8'hC3);
    chk("R6 length register unused", frame_len, 5);

    // R7: zero length
    cpu_wr(0, 0, 0);
    tx_run(n);
    chk("R7 nothing streamed", n, 0);
    chk("R7 not busy", tx_busy, 0);

    // R6: clamp
    cpu_wr(0, 0, 200);
    tx_run(n);
    chk("R6 clamped length", n, DEPTH - 1);

    // R8: tx_start during reception
    cpu_wr(0, 0, 3);
    @(negedge clk); idle_inputs(); rx_start = 1; rx_len = 2;
    @(negedge clk); idle_inputs(); rx_valid = 1; rx_data = 8'h61; tx_start = 1;
    @(negedge clk); idle_inputs();
    chk("R8 start ignored in rx", tx_busy, 0);
    rx_valid = 1; rx_data = 8'h62;
    @(negedge clk); idle_inputs(); rx_done = 1; rx_lqi = 8'h55;
    @(negedge clk); idle_inputs();

    // R11: collision
    cpu_wr(0, 2, 8'h33);
    @(negedge clk); idle_inputs(); rx_start = 1; rx_len = 1;
    @(negedge clk); idle_inputs(); rx_valid = 1; rx_data = 8'h21;
    cpu_en = 1; cpu_we = 1; cpu_from_end = 0; cpu_idx = 2; cpu_wdata = 8'hEE;
    @(negedge clk); idle_inputs(); rx_done = 1; rx_lqi = 8'h44;
    @(negedge clk); idle_inputs();
    cpu_rd(0, 2, v);  chk("R11 controller write lost", v, 8'h33);
    cpu_rd(0, 0, v);  chk("R11 receiver write kept", v, 8'h21);

    // R9 R10: protection
    prot_en = 1;
    rx_frame(3, 8'h40, 8'h99);
    chk("R9 locks after frame", locked, 1);
    rx_frame(2, 8'h50, 8'h98);
    chk("R9 one drop", drop_cnt, 1);
    cpu_rd(0, 0, v);  chk("R9 dropped frame not stored", v, 8'h40);
    chk("R9 length unchanged", frame_len, 3);
    for (int i = 0; i < 3; i++) rx_frame(1, 8'h70, 8'h01);
    chk("R9 drop saturates", drop_cnt, 3);
    @(negedge clk); idle_inputs(); lock_clr = 1;
    @(negedge clk); idle_inputs();
    chk("R10 lock released", locked, 0);
    prot_en = 0;
    rx_frame(1, 8'h60, 8'h02);
    chk("R10 no lock when disabled", locked, 0);
    cpu_rd(0, 0, v);  chk("R10 frame accepted", v, 8'h60);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule